// File: doc/BRIEF.md
# Sampled Adaptive Policy Selector

This unit picks, for a whole set-associative cache, between a cost-weighted linear replacement policy and plain LRU. A small group of sampled sets (the leaders) always runs the linear policy in the main tag store, and a shadow LRU tag directory is kept only for those sets. On each leader access, the main store and the shadow directory both report hit or miss. When only one of them missed, the quantized cost of that miss moves a single saturating selector counter. The counter moves up when the linear policy won and down when LRU won.

Every non-leader (follower) set obeys the top bit of the counter. The block takes one access per cycle. From the set index it works out whether the set is a leader. It then tells the replacement engine which policy applies to that access. The tag arrays and the cost quantizer are outside the block.

Top module: `policy_sel_top`

## Requirements
- R1: After reset the selector counter holds its midpoint 512 (10-bit counter), so follower_lin_o is 1.
- R2: A valid leader access where main_hit_i equals shadow_hit_i leaves the counter unchanged.
- R3: A valid leader access with main_hit_i=1 and shadow_hit_i=0 adds miss_cost_i to the counter, clamping at 1023.
- R4: A valid leader access with main_hit_i=0 and shadow_hit_i=1 subtracts miss_cost_i from the counter, clamping at 0.
- R5: follower_lin_o equals bit 9 of the counter: 1 selects the linear policy, 0 selects LRU.
- R6: leader_o is 1 exactly when acc_set_i[4:0] equals acc_set_i[9:5], which gives 32 leaders out of 1024 sets.
- R7: For a leader set use_lin_o is 1 whatever the counter holds. For a follower set it equals follower_lin_o.
- R8: Follower accesses, and cycles with acc_valid_i low, never change the counter.
- R9: use_lin_o for an access reflects the counter before that access's own update, and the update is visible on sel_cnt_o one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_set_i | input | 10 | Set index of the access |
| main_hit_i | input | 1 | Main tag store hit (linear policy on leaders) |
| shadow_hit_i | input | 1 | Shadow LRU directory hit (meaningful on leaders) |
| miss_cost_i | input | 3 | Quantized cost of the side that missed |
| leader_o | output | 1 | Access set is a leader |
| use_lin_o | output | 1 | Policy for this access: 1 linear, 0 LRU |
| follower_lin_o | output | 1 | Global follower decision (counter top bit) |
| sel_cnt_o | output | 10 | Selector counter value |

## Verification
Two events can fall in the same cycle: a leader update and the policy lookup for that same access. The lookup must see the old counter while the update lands at the next edge. The bench provokes this by walking the counter across its midpoint with leader accesses and following each with a follower access. It judges use_lin_o against a model that was sampled before the update. Saturation at both ends can also coincide with an update that would carry the counter past a boundary. Long runs of cost-7 disagreements drive the counter into each rail, and the bench checks that it clamps there exactly.

// File: rtl/policy_sel_pkg.sv
package policy_sel_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE = 2'b00,
    VOTE_LIN  = 2'b01,
    VOTE_LRU  = 2'b10
  } vote_e;
endpackage

// File: rtl/policy_leader_map.sv
module policy_leader_map #(
  parameter int unsigned SET_W  = 10,
  parameter int unsigned GRP_W  = 5
) (
  input  logic [SET_W-1:0] set_i,
  output logic             leader_o
);
  generate
    if (SET_W >= 2*GRP_W) begin : g_spread
      // leader when low group equals next group: one leader per 2^GRP_W sets
      assign leader_o = (set_i[GRP_W-1:0] == set_i[2*GRP_W-1:GRP_W]);
    end else begin : g_low
      assign leader_o = (set_i[GRP_W-1:0] == '0);
    end
  endgenerate
endmodule

// File: rtl/policy_sat_cnt.sv
module policy_sat_cnt #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MID_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d, step_ext;
  logic [CNT_W:0]   sum;

  assign step_ext = CNT_W'(step_i);
  assign sum      = {1'b0, cnt_q} + {1'b0, step_ext};

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i)      cnt_d = (sum > {1'b0, MAX_V}) ? MAX_V : sum[CNT_W-1:0];
    else if (dec_i) cnt_d = (cnt_q < step_ext) ? '0 : cnt_q - step_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= MID_V;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  inc_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i |=> cnt_q >= $past(cnt_q));
  // R4
  dec_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !inc_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/policy_sel_top.sv
module policy_sel_top #(
  parameter int unsigned SET_W  = 10,
  parameter int unsigned GRP_W  = 5,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned COST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [SET_W-1:0]  acc_set_i,
  input  logic              main_hit_i,
  input  logic              shadow_hit_i,
  input  logic [COST_W-1:0] miss_cost_i,
  output logic              leader_o,
  output logic              use_lin_o,
  output logic              follower_lin_o,
  output logic [CNT_W-1:0]  sel_cnt_o
);
  import policy_sel_pkg::*;

  logic  is_leader;
  vote_e vote;

  policy_leader_map #(.SET_W(SET_W), .GRP_W(GRP_W)) u_map (
    .set_i    (acc_set_i),
    .leader_o (is_leader)
  );

  always_comb begin
    vote = VOTE_NONE;
    if (acc_valid_i && is_leader) begin
      if (main_hit_i && !shadow_hit_i)      vote = VOTE_LIN;
      else if (!main_hit_i && shadow_hit_i) vote = VOTE_LRU;
    end
  end

  policy_sat_cnt #(.CNT_W(CNT_W), .STEP_W(COST_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (vote == VOTE_LIN),
    .dec_i  (vote == VOTE_LRU),
    .step_i (miss_cost_i),
    .cnt_o  (sel_cnt_o)
  );

  assign leader_o       = is_leader;
  assign follower_lin_o = sel_cnt_o[CNT_W-1];
  assign use_lin_o      = is_leader | follower_lin_o;

  // R2
  agree_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && leader_o && (main_hit_i == shadow_hit_i) |=> $stable(sel_cnt_o));
  // R8
  follower_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && leader_o) |=> $stable(sel_cnt_o));
  // R7
  leader_lin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leader_o |-> use_lin_o);
  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && leader_o && main_hit_i && !shadow_hit_i |=>
      (sel_cnt_o - $past(sel_cnt_o)) <= CNT_W'($past(miss_cost_i)));
endmodule

// File: tb/policy_sel_top_test.sv
`timescale 1ns/1ps
module policy_sel_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [9:0] set_idx = '0;
  logic       mh = 1'b0, sh = 1'b0;
  logic [2:0] cost = '0;
  logic       leader, use_lin, fol_lin;
  logic [9:0] cnt;

  int checks = 0, errors = 0;
  int model = 512;

  always #4 clk = ~clk;

  policy_sel_top uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_set_i(set_idx),
    .main_hit_i(mh), .shadow_hit_i(sh), .miss_cost_i(cost),
    .leader_o(leader), .use_lin_o(use_lin), .follower_lin_o(fol_lin), .sel_cnt_o(cnt)
  );

  function automatic bit exp_leader(logic [9:0] s);
    return s[4:0] == s[9:5];
  endfunction

  function automatic int exp_next(int c, bit v, bit ld, bit m, bit s, int k);
    int n = c;
    if (v && ld && m && !s) n = (c + k > 1023) ? 1023 : c + k;
    else if (v && ld && !m && s) n = (c < k) ? 0 : c - k;
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then check counter next negedge
  task automatic access(bit v, logic [9:0] s, bit m, bit h, int k);
    bit ld;
    @(negedge clk);
    chk("R3/R4/R2/R8 counter", cnt, model);
    valid = v; set_idx = s; mh = m; sh = h; cost = 3'(k);
    #1;
    ld = exp_leader(s);
    chk("R6 leader", leader, ld);
    chk("R5 follower", fol_lin, model >= 512);
    chk("R7/R9 use_lin", use_lin, ld ? 1 : (model >= 512));
    model = exp_next(model, v, ld, m, h, k);
  endtask

  function automatic logic [9:0] lead_set(logic [4:0] g);
    return {g, g};
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cnt", cnt, 512);
    chk("R1 reset follower", fol_lin, 1);
    // R2 agree cases
    access(1, lead_set(5'd3), 1, 1, 7);
    access(1, lead_set(5'd3), 0, 0, 7);
    // R9 cross midpoint downward, follower sees old value
    access(1, lead_set(5'd9), 0, 1, 1);
    access(1, 10'h001, 0, 1, 7);       // R8 follower ignored
    access(1, lead_set(5'd9), 1, 0, 1);
    access(1, 10'h002, 1, 0, 7);
    access(0, lead_set(5'd1), 1, 0, 7); // R8 invalid ignored
    access(1, lead_set(5'd0), 1, 0, 0); // cost zero
    // R3 saturate high
    for (int i = 0; i < 100; i++) access(1, lead_set(5'(i)), 1, 0, 7);
    access(1, 10'h3e1, 0, 0, 0);
    chk("R3 clamp max", cnt, 1023);
    // R4 saturate low, with followers between
    for (int i = 0; i < 200; i++) begin
      access(1, lead_set(5'(i)), 0, 1, 7);
      access(1, 10'h044, 1, 0, 7);
    end
    access(1, 10'h003, 0, 0, 0);
    chk("R4 clamp min", cnt, 0);
    chk("R5 lru chosen", fol_lin, 0);
    chk("R7 leader lin at zero", use_lin, exp_leader(10'h003));
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] s = 10'($urandom);
      if ($urandom % 2) s = lead_set(5'($urandom));
      access(bit'($urandom % 8 != 0), s, bit'($urandom), bit'($urandom), int'($urandom % 8));
    end
    access(0, 10'h000, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule